// File: doc/BRIEF.md
# Remappable Secure Address Decoder

This block sits at the entry of an interconnect slave port and decides where each address-phase request goes. It holds a table of address windows. Each window belongs to one destination slave and one of that slave's regions. A 3-bit remap vector switches optional windows on or off, and it can also withdraw one slave from the map altogether. When several windows claim the same address, a fixed priority picks the winner. Remap bit 0 always wins over the other bits.

After the window is chosen, a per-region security bit is checked. Software writes these bits one at a time through a simple write port. A non-secure access that lands in a region marked secure is refused. An address that no window claims is refused as well. In both cases the request is steered to the default slave with a decode-error flag, so it never reaches the real slave.

The decision is registered. The remap vector and the security bits are taken in the cycle the request is presented. Later changes to either leave an issued result untouched.

Top module: `remap_sec_decoder`

## Requirements
- R1: After reset, rsp_valid, rsp_slave, rsp_region and rsp_decerr are all 0, and all eight security bits are 1 (secure).
- R2: With remap 000, requests decode as follows. [0x00000,0x10000) goes to slave 0 region 0. [0x10000,0x20000) goes to slave 0 region 1. [0x20000,0x40000) goes to slave 1 region 0. [0x40000,0x80000) goes to slave 2 region 0. [0xC0000,0x100000) goes to slave 2 region 1.
- R3: Remap bit 1 set, with bit 0 clear, maps [0x00000,0x10000) to slave 1 region 1.
- R4: Remap bit 0 set maps [0x00000,0x10000) to slave 3 region 1, whatever bit 1 is.
- R5: Remap bit 2 set adds [0x80000,0x90000) as slave 3 region 0.
- R6: When remap bits 2 and 0 are both set, no address decodes to slave 1. Its former windows become misses.
- R7: An address claimed by no enabled window gives rsp_decerr=1 with rsp_slave=4 (the default slave) and rsp_region=0.
- R8: A request with req_nonsec=1 that hits a region whose security bit is 1 gives rsp_decerr=1, rsp_slave=4 and rsp_region=0. Two kinds of hit are forwarded normally: a hit with req_nonsec=0, whatever the security bit, and a hit on a region whose bit is 0.
- R9: When sec_we=1, sec_val is written into security bit sec_sel, where sec_sel = slave*2 + region. A request in that same cycle sees the old bit value. Requests from the next cycle on see the new value.
- R10: A request presented with req_valid=1 produces rsp_valid=1 exactly one cycle later. While req_valid=0, rsp_valid is 0 and rsp_slave, rsp_region and rsp_decerr keep their last values, whatever remap, req_nonsec or the security bits do.
- R11: With parameter FORCE_SECURE=1, req_nonsec is ignored. Every request is treated as secure and is never refused for security reasons.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request presented this cycle |
| req_addr | input | ADDR_W | Request address |
| req_nonsec | input | 1 | 1 = non-secure access |
| remap | input | 3 | Remap vector |
| sec_we | input | 1 | Security bit write strobe |
| sec_sel | input | 3 | Security bit index, slave*2+region |
| sec_val | input | 1 | Value written, 1 = secure |
| rsp_valid | output | 1 | Decode result valid |
| rsp_slave | output | 3 | Destination slave, 4 = default slave |
| rsp_region | output | 1 | Region within the destination slave |
| rsp_decerr | output | 1 | Decode error, routed to default slave |

## Verification
A security-bit write and a request can fall in the same cycle. The request then has to be judged against the bit as it was before the write. The bench drives both at the same clock edge: it clears the bit of slave 2 region 0 and then sets it again together with a non-secure request to that region. The expected result is a forwarded request. A repeat of the request one cycle later must be refused. A second case of overlap is two remap bits that claim one window at once. This is provoked by sweeping all eight remap values over a list of window-boundary addresses and judged against an independent range model.

// File: rtl/rsd_pkg.sv
`timescale 1ns/1ps
package rsd_pkg;

    localparam int N_SLV       = 4;
    localparam int RGN_PER_SLV = 2;
    localparam int N_ENTRY     = 8;
    localparam int REMAP_W     = 3;
    localparam int SLV_W       = $clog2(N_SLV + 1);
    localparam int RGN_W       = $clog2(RGN_PER_SLV);
    localparam int SEC_BITS    = N_SLV * RGN_PER_SLV;
    localparam int SEC_IDX_W   = $clog2(SEC_BITS);
    localparam int ENT_IDX_W   = $clog2(N_ENTRY);
    localparam int TBL_AW      = 32;
    localparam int DROP_SLV    = 1;
    localparam logic [REMAP_W-1:0] DROP_MASK = 3'b101;

    typedef enum logic [2:0] {
        EN_NEVER,
        EN_ALWAYS,
        EN_BIT0,
        EN_BIT1,
        EN_BIT2
    } en_rule_e;

    typedef struct packed {
        logic [TBL_AW-1:0] base;
        logic [4:0]        span_log2;
        logic [SLV_W-1:0]  slv;
        logic [RGN_W-1:0]  rgn;
        en_rule_e          rule;
    } win_ent_t;

    typedef struct packed {
        logic             vld;
        logic [SLV_W-1:0] slv;
        logic [RGN_W-1:0] rgn;
        logic             err;
    } rsp_t;

    // Lower index wins when windows overlap.
    function automatic win_ent_t table_entry(input int idx);
        win_ent_t e;
        e = '{base: '0, span_log2: 5'd16, slv: '0, rgn: '0, rule: EN_NEVER};
        case (idx)
            0: e = '{base: 32'h0000_0000, span_log2: 5'd16, slv: 3'd3, rgn: 1'b1, rule: EN_BIT0};
            1: e = '{base: 32'h0000_0000, span_log2: 5'd16, slv: 3'd1, rgn: 1'b1, rule: EN_BIT1};
            2: e = '{base: 32'h0000_0000, span_log2: 5'd16, slv: 3'd0, rgn: 1'b0, rule: EN_ALWAYS};
            3: e = '{base: 32'h0001_0000, span_log2: 5'd16, slv: 3'd0, rgn: 1'b1, rule: EN_ALWAYS};
            4: e = '{base: 32'h0002_0000, span_log2: 5'd17, slv: 3'd1, rgn: 1'b0, rule: EN_ALWAYS};
            5: e = '{base: 32'h0004_0000, span_log2: 5'd18, slv: 3'd2, rgn: 1'b0, rule: EN_ALWAYS};
            6: e = '{base: 32'h0008_0000, span_log2: 5'd16, slv: 3'd3, rgn: 1'b0, rule: EN_BIT2};
            7: e = '{base: 32'h000C_0000, span_log2: 5'd18, slv: 3'd2, rgn: 1'b1, rule: EN_ALWAYS};
            default: e.rule = EN_NEVER;
        endcase
        return e;
    endfunction

    function automatic logic [SLV_W-1:0] entry_slave(input int idx);
        win_ent_t e;
        e = table_entry(idx);
        return e.slv;
    endfunction

    function automatic logic [RGN_W-1:0] entry_region(input int idx);
        win_ent_t e;
        e = table_entry(idx);
        return e.rgn;
    endfunction

endpackage

// File: rtl/rsd_window_match.sv
`timescale 1ns/1ps
module rsd_window_match
    import rsd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [REMAP_W-1:0] remap,
    output logic [N_ENTRY-1:0] hit
);

    logic slv_dropped;
    assign slv_dropped = ((remap & DROP_MASK) == DROP_MASK);

    for (genvar g = 0; g < N_ENTRY; g++) begin : g_win
        localparam win_ent_t E = table_entry(g);
        logic en_d;
        logic in_range;

        always_comb begin
            case (E.rule)
                EN_ALWAYS: en_d = 1'b1;
                EN_BIT0:   en_d = remap[0];
                EN_BIT1:   en_d = remap[1];
                EN_BIT2:   en_d = remap[2];
                default:   en_d = 1'b0;
            endcase
            if ((int'(E.slv) == DROP_SLV) && slv_dropped) begin
                en_d = 1'b0;
            end
        end

        assign in_range = ((addr >> E.span_log2) == (E.base[ADDR_W-1:0] >> E.span_log2));
        assign hit[g]   = en_d && in_range;
    end

endmodule

// File: rtl/rsd_first_hit.sv
`timescale 1ns/1ps
module rsd_first_hit
    import rsd_pkg::*;
(
    input  logic [N_ENTRY-1:0]   hit,
    output logic                 found,
    output logic [ENT_IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_ENTRY - 1; i >= 0; i--) begin
            if (hit[i]) begin
                found = 1'b1;
                idx   = ENT_IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rsd_sec_bank.sv
`timescale 1ns/1ps
module rsd_sec_bank
    import rsd_pkg::*;
#(
    parameter logic [SEC_BITS-1:0] INIT = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEC_IDX_W-1:0] wr_sel,
    input  logic                 wr_val,
    output logic [SEC_BITS-1:0]  bits_q
);

    logic [SEC_BITS-1:0] bits_d;

    always_comb begin
        bits_d = bits_q;
        if (wr_en) begin
            bits_d[wr_sel] = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= INIT;
        end else begin
            bits_q <= bits_d;
        end
    end

    // R9
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> bits_q[$past(wr_sel)] == $past(wr_val));

endmodule

// File: rtl/remap_sec_decoder.sv
`timescale 1ns/1ps
module remap_sec_decoder
    import rsd_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int FORCE_SECURE = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_nonsec,
    input  logic [REMAP_W-1:0]   remap,
    input  logic                 sec_we,
    input  logic [SEC_IDX_W-1:0] sec_sel,
    input  logic                 sec_val,
    output logic                 rsp_valid,
    output logic [SLV_W-1:0]     rsp_slave,
    output logic [RGN_W-1:0]     rsp_region,
    output logic                 rsp_decerr
);

    localparam win_ent_t ALIAS0 = table_entry(0);

    logic [N_ENTRY-1:0]   hit;
    logic                 hit_any;
    logic [ENT_IDX_W-1:0] pick_idx;
    logic [SEC_BITS-1:0]  sec_q;
    logic                 ns_eff;
    logic [SLV_W-1:0]     win_slv;
    logic [RGN_W-1:0]     win_rgn;
    logic [SEC_IDX_W-1:0] sec_idx;
    logic                 refuse;
    rsp_t                 rsp_d;
    rsp_t                 rsp_q;

    if (FORCE_SECURE != 0) begin : g_forced
        assign ns_eff = 1'b0;
    end else begin : g_pass
        assign ns_eff = req_nonsec;
    end

    rsd_window_match #(.ADDR_W(ADDR_W)) u_match (
        .addr  (req_addr),
        .remap (remap),
        .hit   (hit)
    );

    rsd_first_hit u_pick (
        .hit   (hit),
        .found (hit_any),
        .idx   (pick_idx)
    );

    rsd_sec_bank u_sec (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (sec_we),
        .wr_sel (sec_sel),
        .wr_val (sec_val),
        .bits_q (sec_q)
    );

    always_comb begin
        win_slv = entry_slave(int'(pick_idx));
        win_rgn = entry_region(int'(pick_idx));
        sec_idx = SEC_IDX_W'(int'(win_slv) * RGN_PER_SLV + int'(win_rgn));
        refuse  = !hit_any || (ns_eff && sec_q[sec_idx]);

        rsp_d     = rsp_q;
        rsp_d.vld = req_valid;
        if (req_valid) begin
            if (refuse) begin
                rsp_d.slv = SLV_W'(N_SLV);
                rsp_d.rgn = '0;
                rsp_d.err = 1'b1;
            end else begin
                rsp_d.slv = win_slv;
                rsp_d.rgn = win_rgn;
                rsp_d.err = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid  = rsp_q.vld;
    assign rsp_slave  = rsp_q.slv;
    assign rsp_region = rsp_q.rgn;
    assign rsp_decerr = rsp_q.err;

    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(rsp_slave) && $stable(rsp_region) && $stable(rsp_decerr));

    // R7
    default_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_decerr |-> (int'(rsp_slave) == N_SLV) && (rsp_region == '0));

    // R6
    slave_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && ((remap & DROP_MASK) == DROP_MASK) |=> int'(rsp_slave) != DROP_SLV);

    // R4
    bit0_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && remap[0] && ((req_addr >> ALIAS0.span_log2) == '0)
        |=> rsp_decerr || (rsp_slave == ALIAS0.slv));

    // R8
    secure_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !ns_eff && hit_any |=> !rsp_decerr);

endmodule

// File: tb/remap_sec_decoder_tb.sv
`timescale 1ns/1ps
module remap_sec_decoder_tb;

    typedef struct {
        int    slv;
        int    rgn;
        int    err;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_nonsec = 1'b0;
    logic [2:0]  remap = '0;
    logic        sec_we = 1'b0;
    logic [2:0]  sec_sel = '0;
    logic        sec_val = 1'b0;

    logic       a_valid, b_valid;
    logic [2:0] a_slave, b_slave;
    logic       a_region, b_region;
    logic       a_err, b_err;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    bit   [7:0] sec_ref = 8'hFF;
    exp_t q_a[$];
    exp_t q_b[$];

    always #2.5 clk = ~clk;

    remap_sec_decoder #(.ADDR_W(32), .FORCE_SECURE(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_nonsec(req_nonsec), .remap(remap), .sec_we(sec_we), .sec_sel(sec_sel),
        .sec_val(sec_val), .rsp_valid(a_valid), .rsp_slave(a_slave),
        .rsp_region(a_region), .rsp_decerr(a_err)
    );

    remap_sec_decoder #(.ADDR_W(32), .FORCE_SECURE(1)) u_dut_fs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_nonsec(req_nonsec), .remap(remap), .sec_we(sec_we), .sec_sel(sec_sel),
        .sec_val(sec_val), .rsp_valid(b_valid), .rsp_slave(b_slave),
        .rsp_region(b_region), .rsp_decerr(b_err)
    );

    // Range model taken from the requirements (R2..R8).
    function automatic exp_t model(input logic [31:0] a, input logic [2:0] r,
                                   input bit ns, input bit [7:0] sec);
        exp_t e;
        int   s = -1;
        int   g = 0;
        bit   gone = r[2] && r[0];
        if (a < 32'h10000) begin
            if (r[0])      begin s = 3; g = 1; end
            else if (r[1]) begin s = 1; g = 1; end
            else           begin s = 0; g = 0; end
        end else if (a < 32'h20000) begin
            s = 0; g = 1;
        end else if (a < 32'h40000) begin
            if (!gone) begin s = 1; g = 0; end
        end else if (a < 32'h80000) begin
            s = 2; g = 0;
        end else if (a < 32'h90000) begin
            if (r[2]) begin s = 3; g = 0; end
        end else if (a >= 32'hC0000 && a < 32'h100000) begin
            s = 2; g = 1;
        end
        if (s < 0 || (ns && sec[s*2+g])) begin
            e.slv = 4; e.rgn = 0; e.err = 1;
        end else begin
            e.slv = s; e.rgn = g; e.err = 0;
        end
        e.tag = "";
        return e;
    endfunction

    function automatic string sweep_tag(input logic [2:0] r, input exp_t e);
        if (e.err != 0)        return "R7";
        if (r == 3'b000)       return "R2";
        if (r[2] && r[0])      return "R6";
        if (r[0])              return "R4";
        if (r[1])              return "R3";
        return "R5";
    endfunction

    task automatic drive_cycle(input bit do_req, input logic [31:0] a, input logic [2:0] r,
                               input bit ns, input bit do_wr, input int sel, input bit val,
                               input string tag);
        exp_t ea;
        exp_t eb;
        @(negedge clk);
        req_valid  = do_req;
        req_addr   = a;
        remap      = r;
        req_nonsec = ns;
        sec_we     = do_wr;
        sec_sel    = 3'(sel);
        sec_val    = val;
        if (do_req) begin
            ea = model(a, r, ns, sec_ref);
            ea.tag = (tag == "") ? sweep_tag(r, ea) : tag;
            q_a.push_back(ea);
            eb = model(a, r, 1'b0, sec_ref);
            eb.tag = "R11";
            q_b.push_back(eb);
        end
        if (do_wr) sec_ref[sel] = val;
    endtask

    task automatic send(input logic [31:0] a, input logic [2:0] r, input bit ns, input string tag);
        drive_cycle(1'b1, a, r, ns, 1'b0, 0, 1'b0, tag);
    endtask

    task automatic idle();
        drive_cycle(1'b0, 32'h0, 3'b000, 1'b0, 1'b0, 0, 1'b0, "");
    endtask

    task automatic judge(input string who, input exp_t e, input int s, input int g, input int x);
        checks++;
        if (s != e.slv || g != e.rgn || x != e.err) begin
            errors++;
            $display("FAIL %s %s slave/region/err got %0d/%0d/%0d expected %0d/%0d/%0d",
                     e.tag, who, s, g, x, e.slv, e.rgn, e.err);
        end
    endtask

    // Monitor: pop and compare whenever a result appears.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (a_valid) begin
                if (q_a.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R10 unexpected result on main port got valid 1 expected 0");
                end else judge("main", q_a.pop_front(), int'(a_slave), int'(a_region), int'(a_err));
            end
            if (b_valid) begin
                if (q_b.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R10 unexpected result on forced port got valid 1 expected 0");
                end else judge("forced", q_b.pop_front(), int'(b_slave), int'(b_region), int'(b_err));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] probes[12];
        probes = '{32'h0, 32'h0FFFC, 32'h10000, 32'h20000, 32'h3FFFC, 32'h40000,
                   32'h80000, 32'h90000, 32'hC0000, 32'hFFFFC, 32'h100000, 32'hFFFF0000};

        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs after reset
        checks++;
        if (a_valid !== 1'b0 || a_slave !== 3'd0 || a_region !== 1'b0 || a_err !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs got %b/%0d/%b/%b expected 0/0/0/0",
                     a_valid, a_slave, a_region, a_err);
        end

        // R1: security bits reset to secure; R8: secure access passes anyway
        send(32'h0000_0100, 3'b000, 1'b1, "R1");
        send(32'h0000_0100, 3'b000, 1'b0, "R8");

        // R2..R7: sweep every remap value over window boundaries
        for (int r = 0; r < 8; r++) begin
            foreach (probes[p]) send(probes[p], 3'(r), 1'b0, "");
        end
        idle();

        // R9: clear every security bit, then non-secure access passes
        for (int i = 0; i < 8; i++) drive_cycle(1'b0, 32'h0, 3'b000, 1'b0, 1'b1, i, 1'b0, "");
        foreach (probes[p]) send(probes[p], 3'b000, 1'b1, "R9");

        // R9: write and request in one cycle sees the old bit
        drive_cycle(1'b1, 32'h0004_0000, 3'b000, 1'b1, 1'b1, 4, 1'b1, "R9");
        // R8: next request sees the secure bit and is refused
        send(32'h0004_0000, 3'b000, 1'b1, "R8");
        // R8: non-secure access to a non-secure region passes
        send(32'h0002_0000, 3'b000, 1'b1, "R8");
        // R8: secure access to the secure region passes
        send(32'h0007_FFF0, 3'b000, 1'b0, "R8");

        // R10: result holds while inputs and security bits move
        send(32'h0005_0000, 3'b000, 1'b0, "R10");
        drive_cycle(1'b0, 32'h0, 3'b111, 1'b1, 1'b1, 4, 1'b0, "");
        drive_cycle(1'b0, 32'h0009_0000, 3'b101, 1'b1, 1'b1, 5, 1'b1, "");
        idle();
        @(negedge clk);
        checks++;
        if (a_valid !== 1'b0 || a_slave !== 3'd2 || a_region !== 1'b0 || a_err !== 1'b0) begin
            errors++;
            $display("FAIL R10 held result got %b/%0d/%b/%b expected 0/2/0/0",
                     a_valid, a_slave, a_region, a_err);
        end

        // R11: forced-secure instance with secure regions, non-secure flag set
        for (int i = 0; i < 8; i++) drive_cycle(1'b0, 32'h0, 3'b000, 1'b0, 1'b1, i, 1'b1, "");
        send(32'h000C_0000, 3'b000, 1'b1, "R8");
        send(32'h0008_0000, 3'b100, 1'b1, "R8");
        idle();
        repeat (3) idle();

        checks++;
        if (q_a.size() != 0 || q_b.size() != 0) begin
            errors++;
            $display("FAIL R10 outstanding results got %0d/%0d expected 0/0", q_a.size(), q_b.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule